// File: doc/BRIEF.md
# Indexed Register File and Plane Access Router

This block sits between a host CPU bus and a video memory split into four byte-wide planes. The host programs eight control bytes through two index/data port pairs. One pair reaches the five sequencer controls: reset, clocking, plane write mask, font map and memory layout. The other pair reaches three graphics-controller controls: read plane, access mode and window/misc.

Each host memory access is first checked against the active address window. An access inside the window is then steered to planes in one of three ways. In chained mode a plane takes every fourth byte. In odd/even mode even bytes go to planes 0 and 2 and odd bytes go to planes 1 and 3. In linear mode every enabled plane sees the same offset.

The router is purely combinational from the access request to the plane strobes, the plane address and the read-plane select. Register writes take effect on the next clock edge. A few register fields are passed straight out for the display side.

Top module: `seqp_ctrl`

## Requirements
- R1: After reset the control bytes read back as follows. Sequencer index 0 (reset) is 0x03, 1 (clocking) is 0x00, 2 (plane mask) is 0x0F, 3 (font map) is 0x00 and 4 (memory layout) is 0x04. Graphics index 4 (read plane) is 0x00, 5 (access mode) is 0x00 and 6 (window/misc) is 0x00.
- R2: `reg_sel` picks the port: 0 is the sequencer index, 1 the sequencer data, 2 the graphics index and 3 the graphics data. A write with `reg_wr` updates the addressed byte at the next rising clock edge. `reg_rdata` combinationally shows the byte that `reg_sel` and the stored index address.
- R3: A data write to an index with no control byte (sequencer above 4, graphics other than 4 to 6) changes nothing. A data read at such an index returns 0x00.
- R4: Window/misc bits 3:2 pick the host window. 00 is 0xA0000 to 0xBFFFF, 01 is 0xA0000 to 0xAFFFF, 10 is 0xB0000 to 0xBFFFF and 11 is 0xB8000 to 0xBFFFF. The offset is the address minus the window base. `host_hit` is high only for a request inside the window.
- R5: Linear mode applies when memory layout bit 3 is 0 and bit 2 is 1. A write hit drives `plane_we` equal to plane mask bits 3:0, and `plane_addr` equals the offset.
- R6: Odd/even write mode applies when memory layout bit 3 is 0 and bit 2 is 0. A write hit drives `plane_we` = mask & 0101b for an even offset and mask & 1010b for an odd offset. `plane_addr` is the offset shifted right by 1.
- R7: Chained mode applies when memory layout bit 3 is 1 and takes priority over bit 2. A write hit enables only plane offset[1:0], gated by the mask. A read hit selects plane offset[1:0]. `plane_addr` is the offset shifted right by 2.
- R8: Outside chained mode, a read hit raises `plane_re`. If access mode bit 4 is 1, `rd_plane` = {read plane bit 1, offset bit 0} and `plane_addr` = offset >> 1. Otherwise `rd_plane` = read plane bits 1:0 and `plane_addr` = offset.
- R9: While reset-control bit 0 is 0, `plane_we` stays 0000b for every access.
- R10: `char_gen_en` is the inverse of window/misc bit 0. `sync_rst` is the inverse of reset-control bit 1.
- R11: Without a request, or on a miss, `plane_we` is 0000b and `plane_re` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 2 | Port select (index/data for each register group) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| host_req | input | 1 | Host memory access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | HA_W (20) | Host byte address |
| host_hit | output | 1 | Request falls inside the window |
| plane_we | output | 4 | Per-plane write enables |
| plane_re | output | 1 | Plane read strobe |
| rd_plane | output | 2 | Plane selected for a read |
| plane_addr | output | PA_W (16) | Address inside a plane |
| char_gen_en | output | 1 | Glyph generator enabled (text mode) |
| sync_rst | output | 1 | Sequencer synchronous reset request |
| clk_mode | output | 8 | Clocking control byte |
| font_map | output | 8 | Font map select byte |

## Verification
The bench sets up each routing mode and uses byte addresses whose offset parity and low two bits tell the modes apart. A design that ignored the chained-mode priority would route a chained write to two planes. A design that swapped the odd/even masks would write even bytes into odd planes. Accesses at the last byte of a window and at the first byte past it expose an off-by-one window compare; a wrong compare shows up as a missing hit or a stray strobe. It also writes and reads an unmapped index, which catches a decoder that aliases onto a real register. It clears the asynchronous reset bit, which catches strobes that leak through while memory is held.

// File: rtl/seqp_pkg.sv
package seqp_pkg;

   localparam int unsigned NPLANE = 4;
   localparam int unsigned OFS_W  = 17;

   // port select codes
   localparam logic [1:0] SEL_SEQ_IDX = 2'd0;
   localparam logic [1:0] SEL_SEQ_DAT = 2'd1;
   localparam logic [1:0] SEL_GC_IDX  = 2'd2;
   localparam logic [1:0] SEL_GC_DAT  = 2'd3;

   // reset values
   localparam logic [7:0] RST_SEQ_RESET = 8'h03;
   localparam logic [7:0] RST_SEQ_CLK   = 8'h00;
   localparam logic [7:0] RST_SEQ_MASK  = 8'h0F;
   localparam logic [7:0] RST_SEQ_FONT  = 8'h00;
   localparam logic [7:0] RST_SEQ_MEM   = 8'h04;
   localparam logic [7:0] RST_GC_RMAP   = 8'h00;
   localparam logic [7:0] RST_GC_MODE   = 8'h00;
   localparam logic [7:0] RST_GC_MISC   = 8'h00;

   typedef enum logic [1:0] {
      WIN_A0_128K = 2'b00,
      WIN_A0_64K  = 2'b01,
      WIN_B0_64K  = 2'b10,
      WIN_B8_32K  = 2'b11
   } win_sel_e;

   typedef enum logic [1:0] {
      RT_LINEAR = 2'd0,
      RT_ODDEVN = 2'd1,
      RT_CHAIN  = 2'd2
   } route_e;

   // fields the router needs from the control bytes
   typedef struct packed {
      logic       mem_run;     // async reset released
      logic       sync_run;    // sync reset released
      logic [3:0] wr_mask;
      logic       chain;
      logic       oe_wr_n;     // 1 = odd/even write disabled
      logic [1:0] rd_map;
      logic       oe_rd;
      win_sel_e   win;
      logic       gfx;
   } ctl_t;

endpackage

// File: rtl/seqp_regfile.sv
module seqp_regfile
   import seqp_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned SEQ_NREG = 5,
   parameter int unsigned GC_LO    = 4,
   parameter int unsigned GC_HI    = 6
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_sel,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output ctl_t          ctl,
   output logic [DW-1:0] clk_mode,
   output logic [DW-1:0] font_map
);

   localparam int unsigned GC_NREG = GC_HI - GC_LO + 1;

   if (DW != 8) begin : g_chk_dw
      $error("seqp_regfile: DW must be 8");
   end
   if (SEQ_NREG != 5) begin : g_chk_seq
      $error("seqp_regfile: sequencer holds five bytes");
   end
   if (GC_HI < GC_LO) begin : g_chk_gc
      $error("seqp_regfile: graphics index range inverted");
   end

   logic [DW-1:0] seq_idx, gc_idx;
   logic [DW-1:0] seq_q [SEQ_NREG];
   logic [DW-1:0] gc_q  [GC_NREG];
   logic          seq_known, gc_known;
   logic [DW-1:0] gc_rel;

   assign seq_known = (seq_idx < DW'(SEQ_NREG));
   assign gc_known  = (gc_idx >= DW'(GC_LO)) && (gc_idx <= DW'(GC_HI));
   assign gc_rel    = gc_idx - DW'(GC_LO);

   function automatic logic [DW-1:0] seq_rst_val(input int unsigned i);
      case (i)
         0:       return RST_SEQ_RESET;
         1:       return RST_SEQ_CLK;
         2:       return RST_SEQ_MASK;
         3:       return RST_SEQ_FONT;
         default: return RST_SEQ_MEM;
      endcase
   endfunction

   function automatic logic [DW-1:0] gc_rst_val(input int unsigned i);
      case (i)
         0:       return RST_GC_RMAP;
         1:       return RST_GC_MODE;
         default: return RST_GC_MISC;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_idx <= '0;
         gc_idx  <= '0;
      end else if (reg_wr) begin
         if (reg_sel == SEL_SEQ_IDX) seq_idx <= reg_wdata;
         if (reg_sel == SEL_GC_IDX)  gc_idx  <= reg_wdata;
      end
   end

   for (genvar i = 0; i < SEQ_NREG; i++) begin : g_seq
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            seq_q[i] <= seq_rst_val(i);
         else if (reg_wr && reg_sel == SEL_SEQ_DAT && seq_idx == DW'(i))
            seq_q[i] <= reg_wdata;
      end
   end

   for (genvar i = 0; i < GC_NREG; i++) begin : g_gc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            gc_q[i] <= gc_rst_val(i);
         else if (reg_wr && reg_sel == SEL_GC_DAT && gc_known && gc_rel == DW'(i))
            gc_q[i] <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_SEQ_IDX: reg_rdata = seq_idx;
         SEL_SEQ_DAT: if (seq_known) reg_rdata = seq_q[seq_idx[2:0]];
         SEL_GC_IDX:  reg_rdata = gc_idx;
         default:     if (gc_known)  reg_rdata = gc_q[gc_rel[1:0]];
      endcase
   end

   assign ctl.mem_run  = seq_q[0][0];
   assign ctl.sync_run = seq_q[0][1];
   assign ctl.wr_mask  = seq_q[2][3:0];
   assign ctl.chain    = seq_q[4][3];
   assign ctl.oe_wr_n  = seq_q[4][2];
   assign ctl.rd_map   = gc_q[0][1:0];
   assign ctl.oe_rd    = gc_q[1][4];
   assign ctl.win      = win_sel_e'(gc_q[2][3:2]);
   assign ctl.gfx      = gc_q[2][0];
   assign clk_mode     = seq_q[1];
   assign font_map     = seq_q[3];

   // R3: data write at an unmapped sequencer index leaves every byte alone
   a_r3_seq_unknown_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_SEQ_DAT && !seq_known) |=>
         $stable({seq_q[0], seq_q[1], seq_q[2], seq_q[3], seq_q[4]}));

   // R3: same for the graphics group
   a_r3_gc_unknown_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_GC_DAT && !gc_known) |=>
         $stable({gc_q[0], gc_q[1], gc_q[2]}));

   // R2: a data write lands in the addressed byte
   a_r2_seq_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_SEQ_DAT && seq_idx == 8'd2) |=>
         (ctl.wr_mask == $past(reg_wdata[3:0])));

endmodule

// File: rtl/seqp_window.sv
module seqp_window
   import seqp_pkg::*;
#(
   parameter int unsigned HA_W = 20
)(
   input  logic            host_req,
   input  logic [HA_W-1:0] host_addr,
   input  win_sel_e        win,
   output logic            hit,
   output logic [OFS_W-1:0] offset
);

   if (HA_W != 20) begin : g_chk_haw
      $error("seqp_window: host address must be 20 bits");
   end

   logic in_win;

   always_comb begin
      in_win = 1'b0;
      offset = '0;
      case (win)
         WIN_A0_128K: begin
            in_win = (host_addr[19:17] == 3'b101);
            offset = host_addr[16:0];
         end
         WIN_A0_64K: begin
            in_win = (host_addr[19:16] == 4'hA);
            offset = {1'b0, host_addr[15:0]};
         end
         WIN_B0_64K: begin
            in_win = (host_addr[19:16] == 4'hB);
            offset = {1'b0, host_addr[15:0]};
         end
         default: begin
            in_win = (host_addr[19:15] == 5'b10111);
            offset = {2'b00, host_addr[14:0]};
         end
      endcase
   end

   assign hit = host_req && in_win;

endmodule

// File: rtl/seqp_route.sv
module seqp_route
   import seqp_pkg::*;
#(
   parameter int unsigned PA_W = 16
)(
   input  ctl_t             ctl,
   input  logic             hit,
   input  logic             host_we,
   input  logic [OFS_W-1:0] offset,
   output logic [NPLANE-1:0] plane_we,
   output logic             plane_re,
   output logic [1:0]       rd_plane,
   output logic [PA_W-1:0]  plane_addr
);

   if (PA_W < 15 || PA_W > OFS_W) begin : g_chk_paw
      $error("seqp_route: plane address width out of range");
   end

   route_e           wr_rt;
   logic [OFS_W-1:0] wr_shift, rd_shift, sel_shift;
   logic [NPLANE-1:0] lane, we_raw;

   always_comb begin
      if (ctl.chain)         wr_rt = RT_CHAIN;
      else if (!ctl.oe_wr_n) wr_rt = RT_ODDEVN;
      else                   wr_rt = RT_LINEAR;
   end

   for (genvar p = 0; p < NPLANE; p++) begin : g_lane
      assign lane[p] = (wr_rt == RT_CHAIN)  ? (offset[1:0] == 2'(p)) :
                       (wr_rt == RT_ODDEVN) ? (offset[0] == p[0])    :
                                              1'b1;
   end

   always_comb begin
      case (wr_rt)
         RT_CHAIN:  wr_shift = offset >> 2;
         RT_ODDEVN: wr_shift = offset >> 1;
         default:   wr_shift = offset;
      endcase
   end

   always_comb begin
      if (ctl.chain) begin
         rd_plane = offset[1:0];
         rd_shift = offset >> 2;
      end else if (ctl.oe_rd) begin
         rd_plane = {ctl.rd_map[1], offset[0]};
         rd_shift = offset >> 1;
      end else begin
         rd_plane = ctl.rd_map;
         rd_shift = offset;
      end
   end

   assign we_raw     = lane & ctl.wr_mask;
   assign plane_we   = (hit && host_we && ctl.mem_run) ? we_raw : '0;
   assign plane_re   = hit && !host_we;
   assign sel_shift  = host_we ? wr_shift : rd_shift;
   assign plane_addr = sel_shift[PA_W-1:0];

   // R7: a chained write never touches more than one plane
   always_comb begin
      a_r7_chain_single: assert (!(ctl.chain) || $onehot0(plane_we));
   end

   // R6: in odd/even write mode the lane parity matches the offset parity
   always_comb begin
      a_r6_parity_lanes: assert (ctl.chain || ctl.oe_wr_n || !hit ||
         (offset[0] ? ((plane_we & 4'b0101) == 4'b0000)
                    : ((plane_we & 4'b1010) == 4'b0000)));
   end

endmodule

// File: rtl/seqp_ctrl.sv
module seqp_ctrl
   import seqp_pkg::*;
#(
   parameter int unsigned HA_W = 20,
   parameter int unsigned PA_W = 16
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [1:0]      reg_sel,
   input  logic [7:0]      reg_wdata,
   output logic [7:0]      reg_rdata,
   input  logic            host_req,
   input  logic            host_we,
   input  logic [HA_W-1:0] host_addr,
   output logic            host_hit,
   output logic [3:0]      plane_we,
   output logic            plane_re,
   output logic [1:0]      rd_plane,
   output logic [PA_W-1:0] plane_addr,
   output logic            char_gen_en,
   output logic            sync_rst,
   output logic [7:0]      clk_mode,
   output logic [7:0]      font_map
);

   ctl_t             ctl;
   logic [OFS_W-1:0] offset;

   seqp_regfile #(.DW(8), .SEQ_NREG(5), .GC_LO(4), .GC_HI(6)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ctl       (ctl),
      .clk_mode  (clk_mode),
      .font_map  (font_map)
   );

   seqp_window #(.HA_W(HA_W)) u_win (
      .host_req  (host_req),
      .host_addr (host_addr),
      .win       (ctl.win),
      .hit       (host_hit),
      .offset    (offset)
   );

   seqp_route #(.PA_W(PA_W)) u_route (
      .ctl        (ctl),
      .hit        (host_hit),
      .host_we    (host_we),
      .offset     (offset),
      .plane_we   (plane_we),
      .plane_re   (plane_re),
      .rd_plane   (rd_plane),
      .plane_addr (plane_addr)
   );

   assign char_gen_en = !ctl.gfx;
   assign sync_rst    = !ctl.sync_run;

   // R9: memory held in reset means no plane strobes
   a_r9_async_blocks_we: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.mem_run |-> (plane_we == 4'b0000));

   // R11: a miss or idle bus produces no strobes
   a_r11_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !host_hit |-> (plane_we == 4'b0000 && !plane_re));

   // R8: reads and writes never strobe together
   a_r8_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      plane_re |-> (plane_we == 4'b0000));

endmodule

// File: tb/seqp_ctrl_bench.sv
module seqp_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [19:0] host_addr = 20'h0;
   logic        host_hit;
   logic [3:0]  plane_we;
   logic        plane_re;
   logic [1:0]  rd_plane;
   logic [15:0] plane_addr;
   logic        char_gen_en;
   logic        sync_rst;
   logic [7:0]  clk_mode;
   logic [7:0]  font_map;

   always #10 clk = ~clk;   // 50 MHz

   seqp_ctrl u_seqp_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_req(host_req),
      .host_we(host_we), .host_addr(host_addr), .host_hit(host_hit),
      .plane_we(plane_we), .plane_re(plane_re), .rd_plane(rd_plane),
      .plane_addr(plane_addr), .char_gen_en(char_gen_en),
      .sync_rst(sync_rst), .clk_mode(clk_mode), .font_map(font_map));

   typedef struct {
      int          kind;   // 0 reg byte, 1 host route, 2 mode pins
      logic [7:0]  rdata;
      logic        hit;
      logic [3:0]  we;
      logic        re;
      logic [1:0]  rp;
      logic [15:0] pa;
      logic        cg;
      logic        sr;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   event sample_ev;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   // monitor: pops expectations and compares against the ports
   initial begin
      forever begin
         @(sample_ev);
         #1;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (e.kind == 0) begin
               if (reg_rdata !== e.rdata) begin
                  errors++;
                  $display("FAIL %s rdata act=%h exp=%h", e.tag, reg_rdata, e.rdata);
               end
            end else if (e.kind == 1) begin
               if (host_hit !== e.hit || plane_we !== e.we || plane_re !== e.re ||
                   (e.hit && plane_addr !== e.pa) || (e.re && rd_plane !== e.rp)) begin
                  errors++;
                  $display("FAIL %s act hit=%b we=%b re=%b rp=%0d pa=%h exp hit=%b we=%b re=%b rp=%0d pa=%h",
                           e.tag, host_hit, plane_we, plane_re, rd_plane, plane_addr,
                           e.hit, e.we, e.re, e.rp, e.pa);
               end
            end else begin
               if (char_gen_en !== e.cg || sync_rst !== e.sr) begin
                  errors++;
                  $display("FAIL %s act cg=%b sr=%b exp cg=%b sr=%b",
                           e.tag, char_gen_en, sync_rst, e.cg, e.sr);
               end
            end
         end
      end
   end

   task automatic wr_port(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_seq(input logic [7:0] idx, input logic [7:0] d);
      wr_port(2'd0, idx);
      wr_port(2'd1, d);
   endtask

   task automatic set_gc(input logic [7:0] idx, input logic [7:0] d);
      wr_port(2'd2, idx);
      wr_port(2'd3, d);
   endtask

   task automatic chk_reg(input logic [1:0] grp, input logic [7:0] idx,
                          input logic [7:0] expv, input string tag);
      exp_t e;
      wr_port(grp, idx);
      reg_sel = grp + 2'd1;
      e = '{kind:0, rdata:expv, hit:0, we:0, re:0, rp:0, pa:0, cg:0, sr:0, tag:tag};
      exp_q.push_back(e);
      -> sample_ev;
      @(negedge clk);
   endtask

   task automatic chk_host(input logic we, input logic [19:0] a, input logic hit,
                           input logic [3:0] pwe, input logic [1:0] rp,
                           input logic [15:0] pa, input string tag);
      exp_t e;
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = a;
      e = '{kind:1, rdata:0, hit:hit, we:pwe, re:(hit && !we), rp:rp, pa:pa,
            cg:0, sr:0, tag:tag};
      exp_q.push_back(e);
      -> sample_ev;
      @(negedge clk);
      host_req = 1'b0;
   endtask

   task automatic chk_pins(input logic cg, input logic sr, input string tag);
      exp_t e;
      @(negedge clk);
      e = '{kind:2, rdata:0, hit:0, we:0, re:0, rp:0, pa:0, cg:cg, sr:sr, tag:tag};
      exp_q.push_back(e);
      -> sample_ev;
      @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      chk_reg(2'd0, 8'd0, 8'h03, "R1 seq reset");
      chk_reg(2'd0, 8'd2, 8'h0F, "R1 seq mask");
      chk_reg(2'd0, 8'd4, 8'h04, "R1 seq memlayout");
      chk_reg(2'd2, 8'd6, 8'h00, "R1 gc misc");
      chk_pins(1'b1, 1'b0, "R1 R10 pins at reset");

      // R5 linear, R4 window 00
      chk_host(1'b1, 20'hA0005, 1'b1, 4'b1111, 2'd0, 16'h0005, "R5 linear write");
      chk_host(1'b1, 20'hC0000, 1'b0, 4'b0000, 2'd0, 16'h0000, "R4 R11 past 128K window");
      chk_host(1'b1, 20'hBFFFF, 1'b1, 4'b1111, 2'd0, 16'hFFFF, "R4 last byte 128K");

      // R2 mask write
      set_seq(8'd2, 8'h04);
      chk_host(1'b1, 20'hA1234, 1'b1, 4'b0100, 2'd0, 16'h1234, "R2 R5 masked write");

      // R3 unknown index
      set_seq(8'd7, 8'hFF);
      chk_reg(2'd0, 8'd7, 8'h00, "R3 seq unknown read");
      chk_reg(2'd0, 8'd2, 8'h04, "R3 seq mask untouched");
      set_gc(8'd2, 8'hFF);
      chk_reg(2'd2, 8'd6, 8'h00, "R3 gc misc untouched");

      // R6 odd/even, window 11
      set_gc(8'd6, 8'h0C);
      set_seq(8'd4, 8'h03);
      set_seq(8'd2, 8'h03);
      chk_host(1'b1, 20'hB8001, 1'b1, 4'b0010, 2'd0, 16'h0000, "R6 odd byte");
      chk_host(1'b1, 20'hB8000, 1'b1, 4'b0001, 2'd0, 16'h0000, "R6 even byte");
      chk_host(1'b1, 20'hB7FFF, 1'b0, 4'b0000, 2'd0, 16'h0000, "R4 below 32K window");

      // R8 read routing
      set_gc(8'd5, 8'h10);
      chk_host(1'b0, 20'hB8003, 1'b1, 4'b0000, 2'd1, 16'h0001, "R8 oe read map0");
      set_gc(8'd4, 8'h02);
      chk_host(1'b0, 20'hB8002, 1'b1, 4'b0000, 2'd2, 16'h0001, "R8 oe read map2");
      set_gc(8'd5, 8'h00);
      chk_host(1'b0, 20'hB8005, 1'b1, 4'b0000, 2'd2, 16'h0005, "R8 linear read");

      // R7 chained, window 01
      set_seq(8'd4, 8'h08);
      set_seq(8'd2, 8'h0F);
      set_gc(8'd6, 8'h04);
      chk_host(1'b1, 20'hA0007, 1'b1, 4'b1000, 2'd0, 16'h0001, "R7 chain write");
      chk_host(1'b0, 20'hA0006, 1'b1, 4'b0000, 2'd2, 16'h0001, "R7 chain read");
      chk_host(1'b1, 20'hB0000, 1'b0, 4'b0000, 2'd0, 16'h0000, "R4 past A0 64K");

      // R9 async reset
      set_seq(8'd0, 8'h02);
      chk_host(1'b1, 20'hA0007, 1'b1, 4'b0000, 2'd0, 16'h0001, "R9 async holds we");
      set_seq(8'd0, 8'h01);
      chk_pins(1'b1, 1'b1, "R10 sync reset pin");
      chk_host(1'b1, 20'hA0007, 1'b1, 4'b1000, 2'd0, 16'h0001, "R9 released");

      // R10 graphics bit, R4 window 10
      set_gc(8'd6, 8'h09);
      chk_pins(1'b0, 1'b1, "R10 graphics mode");
      chk_host(1'b1, 20'hBFFFF, 1'b1, 4'b1000, 2'd0, 16'h3FFF, "R4 R7 last B0 byte");
      chk_host(1'b1, 20'hAFFFF, 1'b0, 4'b0000, 2'd0, 16'h0000, "R4 below B0 window");

      // R11 no request
      @(negedge clk);
      host_req = 1'b0; host_we = 1'b1; host_addr = 20'hB0000;
      begin
         exp_t e;
         e = '{kind:1, rdata:0, hit:0, we:0, re:0, rp:0, pa:0, cg:0, sr:0,
               tag:"R11 idle"};
         exp_q.push_back(e);
      end
      -> sample_ev;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule